// File: doc/BRIEF.md
# Bitwise Ternary Logic Unit

This block evaluates any Boolean function of three inputs independently at each of 64 bit positions. An 8-bit immediate is the truth table of the function. Two source operands, called A and B, feed two of the three inputs. A select code picks the value that feeds the third input. The only code accepted for this operation is the one that picks the old contents of the destination register. The result then replaces that register's value, so a single operation reads the destination and overwrites it.

Requests arrive on a valid/ready handshake, and results leave on a second valid/ready handshake after one register stage. A request with any other select code still completes both handshakes. Its result is marked with an error flag and its data is forced to zero. The reset input is asynchronous and active-low. Inside the block, the release of reset is synchronised to the clock by two flops. The unit accepts no request until that release has passed through both flops.

Top module: `ternlog_unit`

## Requirements
- R1: For an accepted request with select code 6, result bit i equals `in_imm[{in_op_dst[i], in_src_a[i], in_src_b[i]}]`: the destination bit is index bit 2, A is index bit 1 and B is index bit 0.
- R2: An immediate of 0x00 gives an all-zeros result, and an immediate of 0xFF gives an all-ones result.
- R3: An immediate of 0xCC returns A unchanged, 0xAA returns B unchanged and 0xF0 returns the old destination value unchanged.
- R4: A request whose select code is not 6 (3 = FRS operand, 4 = FRC operand, 5 = C register, or any other value) is accepted and answered with `out_err` = 1 and `out_data` = 0.
- R5: A request is accepted on a rising edge where `in_valid` and `in_ready` are both 1. `out_valid` is 0 before that edge if no result is pending, and `out_valid` is 1 after that edge.
- R6: While `out_valid` is 1 and `out_ready` is 0, `out_valid`, `out_data` and `out_err` do not change, even if a new request is offered.
- R7: `in_ready` is 0 while a result is held with `out_ready` at 0, and `in_ready` is 1 whenever no result is pending after reset.
- R8: After reset, `out_valid`, `out_data` and `out_err` are 0, and `in_ready` becomes 1 two clock edges after `rst_n` rises.
- R9: When a held result is taken and a new request is offered in the same cycle, both happen on one edge: `in_ready` is 1 in that cycle and the new result follows one cycle later.
- R10: A request with select code 6 is answered with `out_err` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised inside the block |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request can be accepted |
| in_sel | input | 3 | Third-operand select code (6 = old destination value) |
| in_imm | input | 8 | Truth-table immediate |
| in_op_fs | input | 64 | FRS operand candidate (code 3) |
| in_op_fc | input | 64 | FRC operand candidate (code 4) |
| in_op_c | input | 64 | C register candidate (code 5) |
| in_op_dst | input | 64 | Old destination register value (code 6) |
| in_src_a | input | 64 | Source operand A |
| in_src_b | input | 64 | Source operand B |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Result taken by the consumer |
| out_data | output | 64 | Result value |
| out_err | output | 1 | Illegal third-operand select |

## Verification
The bench checks the identity immediates 0xCC, 0xAA and 0xF0. A design that orders the index bits wrongly returns the wrong operand for these, or a scrambled mix of operands. The constant immediates 0x00 and 0xFF catch a design that gates or inverts the output wrongly. Each of the three neighbouring select codes, plus out-of-range codes, must give the error flag with zero data. A design that trusts the mux instead would leak the FRS, FRC or C operand onto the output. Under back-pressure, a second request is offered while a result is held. A design that overwrites the held result, or that stalls instead of taking a result and accepting a request on the same edge, shows a changed output or a lost request.

// File: rtl/ternlog_pkg.sv
package ternlog_pkg;
  localparam int unsigned TL_IDX_W = 3;
  localparam int unsigned TL_TT_W  = 1 << TL_IDX_W;
  localparam int unsigned TL_SEL_W = 3;

  localparam logic [TL_SEL_W-1:0] TL_SEL_FS  = 3'd3;
  localparam logic [TL_SEL_W-1:0] TL_SEL_FC  = 3'd4;
  localparam logic [TL_SEL_W-1:0] TL_SEL_C   = 3'd5;
  localparam logic [TL_SEL_W-1:0] TL_SEL_DST = 3'd6;
endpackage

// File: rtl/ternlog_rst_sync.sv
module ternlog_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/ternlog_opsel.sv
module ternlog_opsel
  import ternlog_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [TL_SEL_W-1:0] sel,
  input  logic [W-1:0]        op_fs,
  input  logic [W-1:0]        op_fc,
  input  logic [W-1:0]        op_c,
  input  logic [W-1:0]        op_dst,
  output logic [W-1:0]        third,
  output logic                legal
);
  // Only the old destination value is a legal third input for this operation.
  always_comb begin
    third = '0;
    legal = 1'b0;
    unique case (sel)
      TL_SEL_FS:  third = op_fs;
      TL_SEL_FC:  third = op_fc;
      TL_SEL_C:   third = op_c;
      TL_SEL_DST: begin
        third = op_dst;
        legal = 1'b1;
      end
      default:    third = '0;
    endcase
  end
endmodule

// File: rtl/ternlog_lut.sv
module ternlog_lut
  import ternlog_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic [TL_TT_W-1:0] imm,
  input  logic [W-1:0]       op_hi,
  input  logic [W-1:0]       op_mid,
  input  logic [W-1:0]       op_lo,
  input  logic               legal,
  output logic [W-1:0]       res
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [TL_IDX_W-1:0] idx;
    assign idx    = {op_hi[i], op_mid[i], op_lo[i]};
    assign res[i] = legal & imm[idx];
  end
endmodule

// File: rtl/ternlog_outreg.sv
module ternlog_outreg #(
  parameter int unsigned W = 64
) (
  input  logic         clk,
  input  logic         srst_n,
  input  logic         load,
  input  logic         take,
  input  logic [W-1:0] res_d,
  input  logic         err_d,
  output logic         vld_q,
  output logic [W-1:0] res_q,
  output logic         err_q
);
  logic vld_n;

  always_comb begin
    vld_n = vld_q;
    if (load) begin
      vld_n = 1'b1;
    end else if (take) begin
      vld_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_n;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      res_q <= '0;
      err_q <= 1'b0;
    end else if (load) begin
      res_q <= res_d;
      err_q <= err_d;
    end
  end
endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
  import ternlog_pkg::*;
#(
  parameter int unsigned W = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [TL_SEL_W-1:0] in_sel,
  input  logic [TL_TT_W-1:0]  in_imm,
  input  logic [W-1:0]        in_op_fs,
  input  logic [W-1:0]        in_op_fc,
  input  logic [W-1:0]        in_op_c,
  input  logic [W-1:0]        in_op_dst,
  input  logic [W-1:0]        in_src_a,
  input  logic [W-1:0]        in_src_b,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [W-1:0]        out_data,
  output logic                out_err
);
  logic         srst_n;
  logic [W-1:0] third;
  logic         legal;
  logic [W-1:0] lut_res;
  logic         load;
  logic         take;

  ternlog_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  ternlog_opsel #(.W(W)) u_opsel (
    .sel    (in_sel),
    .op_fs  (in_op_fs),
    .op_fc  (in_op_fc),
    .op_c   (in_op_c),
    .op_dst (in_op_dst),
    .third  (third),
    .legal  (legal)
  );

  ternlog_lut #(.W(W)) u_lut (
    .imm    (in_imm),
    .op_hi  (third),
    .op_mid (in_src_a),
    .op_lo  (in_src_b),
    .legal  (legal),
    .res    (lut_res)
  );

  assign take     = out_valid & out_ready;
  assign in_ready = srst_n & (~out_valid | out_ready);
  assign load     = in_valid & in_ready;

  ternlog_outreg #(.W(W)) u_outreg (
    .clk    (clk),
    .srst_n (srst_n),
    .load   (load),
    .take   (take),
    .res_d  (lut_res),
    .err_d  (~legal),
    .vld_q  (out_valid),
    .res_q  (out_data),
    .err_q  (out_err)
  );
endmodule

// File: rtl/ternlog_unit_chk.sv
module ternlog_unit_chk #(
  parameter int unsigned W = 64
) (
  input logic         clk,
  input logic         srst_n,
  input logic         in_valid,
  input logic         in_ready,
  input logic [2:0]   in_sel,
  input logic [7:0]   in_imm,
  input logic [W-1:0] in_src_a,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_data,
  input logic         out_err
);
  assert_accept_gives_valid_R5: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready) |=> out_valid);

  assert_hold_stable_R6: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_err)));

  assert_no_accept_when_held_R7: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && !out_ready) |-> !in_ready);

  assert_idle_ready_R7: assert property (@(posedge clk) disable iff (!srst_n)
    !out_valid |-> in_ready);

  assert_err_zero_data_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (out_valid && out_err) |-> (out_data == '0));

  assert_bad_sel_flag_R4: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && in_sel != 3'd6) |=> out_err);

  assert_good_sel_clean_R10: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && in_sel == 3'd6) |=> !out_err);

  assert_copy_a_R3: assert property (@(posedge clk) disable iff (!srst_n)
    (in_valid && in_ready && in_sel == 3'd6 && in_imm == 8'hCC) |=> (out_data == $past(in_src_a)));
endmodule

bind ternlog_unit ternlog_unit_chk #(.W(W)) u_chk (
  .clk       (clk),
  .srst_n    (srst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_sel    (in_sel),
  .in_imm    (in_imm),
  .in_src_a  (in_src_a),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_err   (out_err)
);

// File: tb/ternlog_unit_bench.sv
module ternlog_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W = 64;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [2:0]   in_sel;
  logic [7:0]   in_imm;
  logic [W-1:0] in_op_fs, in_op_fc, in_op_c, in_op_dst, in_src_a, in_src_b;
  logic         out_valid;
  logic         out_ready;
  logic [W-1:0] out_data;
  logic         out_err;

  int checks = 0;
  int failures = 0;
  logic [W-1:0] lcg = 64'h0123_4567_89AB_CDEF;

  ternlog_unit #(.W(W)) u_ternlog_unit (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_imm(in_imm), .in_op_fs(in_op_fs), .in_op_fc(in_op_fc),
    .in_op_c(in_op_c), .in_op_dst(in_op_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_err(out_err)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [7:0] imm, input logic [W-1:0] d,
                                         input logic [W-1:0] a, input logic [W-1:0] b);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = imm[{d[i], a[i], b[i]}];
    return r;
  endfunction

  function automatic logic [W-1:0] next_rand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] sel, input logic [7:0] imm, input logic [W-1:0] d,
                       input logic [W-1:0] a, input logic [W-1:0] b);
    in_sel = sel; in_imm = imm; in_op_dst = d; in_src_a = a; in_src_b = b;
    in_op_fs = ~a; in_op_fc = a ^ b; in_op_c = ~b;
    in_valid = 1'b1;
  endtask

  // One request with the consumer always ready; checks timing and value.
  task automatic send(input string tag, input logic [2:0] sel, input logic [7:0] imm,
                      input logic [W-1:0] d, input logic [W-1:0] a, input logic [W-1:0] b,
                      input logic [W-1:0] exp, input logic exp_err);
    @(negedge clk);
    out_ready = 1'b1;
    drive(sel, imm, d, a, b);
    chk({tag, " R5 valid low before accept"}, W'(out_valid), '0);
    chk({tag, " R7 ready when idle"}, W'(in_ready), W'(1));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({tag, " R5 valid after accept"}, W'(out_valid), W'(1));
    chk({tag, " data"}, out_data, exp);
    chk({tag, " err"}, W'(out_err), W'(exp_err));
  endtask

  task automatic t_reset();
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b0;
    in_sel = '0; in_imm = '0; in_op_fs = '0; in_op_fc = '0; in_op_c = '0;
    in_op_dst = '0; in_src_a = '0; in_src_b = '0;
    repeat (3) @(negedge clk);
    chk("R8 valid in reset", W'(out_valid), '0);
    chk("R8 ready in reset", W'(in_ready), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R8 ready held one edge", W'(in_ready), '0);
    @(negedge clk);
    chk("R8 ready after two edges", W'(in_ready), W'(1));
    chk("R8 data cleared", out_data, '0);
    chk("R8 err cleared", W'(out_err), '0);
    chk("R8 valid cleared", W'(out_valid), '0);
  endtask

  task automatic t_const();
    logic [W-1:0] d = next_rand(), a = next_rand(), b = next_rand();
    send("R2 imm00", 3'd6, 8'h00, d, a, b, '0, 1'b0);
    send("R2 immFF", 3'd6, 8'hFF, d, a, b, '1, 1'b0);
  endtask

  task automatic t_identity();
    logic [W-1:0] d = next_rand(), a = next_rand(), b = next_rand();
    send("R3 immCC gives A", 3'd6, 8'hCC, d, a, b, a, 1'b0);
    send("R3 immAA gives B", 3'd6, 8'hAA, d, a, b, b, 1'b0);
    send("R3 immF0 gives dst", 3'd6, 8'hF0, d, a, b, d, 1'b0);
  endtask

  task automatic t_general();
    logic [7:0] imms[6] = '{8'h96, 8'hE8, 8'h01, 8'h80, 8'h3C, 8'h5A};
    for (int k = 0; k < 6; k++) begin
      logic [W-1:0] d = next_rand(), a = next_rand(), b = next_rand();
      send("R1 R10 lookup", 3'd6, imms[k], d, a, b, model(imms[k], d, a, b), 1'b0);
    end
    send("R1 single bits", 3'd6, 8'h10, 64'h1, 64'h0, 64'h0, 64'h1, 1'b0);
  endtask

  task automatic t_illegal();
    logic [2:0] sels[5] = '{3'd3, 3'd4, 3'd5, 3'd0, 3'd7};
    for (int k = 0; k < 5; k++) begin
      logic [W-1:0] a = next_rand(), b = next_rand();
      send("R4 bad select", sels[k], 8'hFF, next_rand(), a, b, '0, 1'b1);
    end
  endtask

  task automatic t_backpressure();
    logic [W-1:0] d1 = next_rand(), a1 = next_rand(), b1 = next_rand();
    logic [W-1:0] d2 = next_rand(), a2 = next_rand(), b2 = next_rand();
    logic [W-1:0] e1 = model(8'h96, d1, a1, b1);
    logic [W-1:0] e2 = model(8'h17, d2, a2, b2);
    @(negedge clk);
    out_ready = 1'b0;
    drive(3'd6, 8'h96, d1, a1, b1);
    @(posedge clk);
    @(negedge clk);
    drive(3'd6, 8'h17, d2, a2, b2);
    chk("R6 first held", out_data, e1);
    chk("R7 ready low while held", W'(in_ready), '0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R6 valid stays", W'(out_valid), W'(1));
      chk("R6 data stable", out_data, e1);
      chk("R7 ready stays low", W'(in_ready), '0);
    end
    out_ready = 1'b1;
    #1;
    chk("R9 ready with take", W'(in_ready), W'(1));
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 next valid", W'(out_valid), W'(1));
    chk("R9 next data", out_data, e2);
    @(posedge clk);
    @(negedge clk);
    chk("R5 drained", W'(out_valid), '0);
  endtask

  initial begin
    t_reset();
    t_const();
    t_identity();
    t_general();
    t_illegal();
    t_backpressure();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule